// File: doc/BRIEF.md
# Biphase-Mark Clock and Data Recovery

This block takes a single serial line that carries biphase-mark coded data and recovers a bit clock and the data bits from it. The line is asynchronous to the block and is sampled by a local oversampling clock. A two-stage synchroniser and an edge detector feed a cell timer. The cell timer measures where each line transition falls inside the current bit cell. A transition near the end of a cell starts the next cell, and a transition near the middle marks the cell as a one.

A 2-bit rate selector sets the bit cell length. The same logic then decodes a base line rate (nominally 40 Mb/s) or two, four or eight times that rate (80, 160 and 320 Mb/s). At the fastest rate a cell lasts `SPB_FAST` clocks, and each halving of the rate doubles the cell length. The block drives a recovered clock level, a data bit with a one-cycle valid strobe, and a loss-of-lock flag. The flag stays high until enough well-framed cells have been decoded. It returns high when the line goes quiet, when a transition arrives too early in a cell, or when the rate changes.

Top module: `bpm_cdr`

## Requirements
- R1: `rate_i` values 0, 1, 2 and 3 select cell lengths N of 64, 32, 16 and 8 clocks (with `SPB_FAST` = 8). Every cell is decoded correctly at each of the four settings.
- R2: Every cell opens with a line transition. A cell with one more transition near its middle decodes as 1, and a cell with none decodes as 0. Bits come out in line order, one per cell, each with a single-cycle `bit_vld_o` pulse, and two pulses are never adjacent.
- R3: Suppose the transition that opens the following cell is presented before clock edge k. Then `bit_vld_o` and `bit_o` for the previous cell are valid after edge k+2. The first cell after acquisition is reported when the second cell opens, and the last cell before silence is never reported.
- R4: Time is measured in clocks since the cell opened. A transition between 3N/8 and 5N/8 is a mid-cell mark, and a transition later than 5N/8 opens the next cell. Timing jitter of one clock on every transition still decodes correctly at every rate.
- R5: `rclk_o` goes high on the same edge as each `bit_vld_o` (and on the first cell opening) and stays high for N/2 cycles. It stays low while the decoder is not framed.
- R6: `lol_o` clears on the same edge as the 16th `bit_vld_o` pulse after framing is acquired.
- R7: Suppose the last line transition is presented before edge k and no further transition follows. Then `lol_o` is still 0 after edge k+4N+1 and becomes 1 after edge k+4N+2. Framing is dropped at that point, so `rclk_o` is 0.
- R8: A transition less than 3N/8 clocks into a framed cell is a framing error. It raises `lol_o` 3 edges after it is presented, the cell gives no bit, and relocking again requires 16 bits.
- R9: A change of `rate_i` raises `lol_o` on the next clock edge and drops framing.
- R10: `rst` is synchronous and active high. While it is held and right after it, `bit_o`, `bit_vld_o` and `rclk_o` are 0 and `lol_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous biphase-mark serial line |
| rate_i | input | 2 | Rate select: 0 base, 1 double, 2 quadruple, 3 eightfold |
| bit_o | output | 1 | Recovered data bit, held between strobes |
| bit_vld_o | output | 1 | One-cycle strobe marking a new `bit_o` |
| rclk_o | output | 1 | Recovered clock, high for the first half of each framed cell |
| lol_o | output | 1 | Loss-of-lock flag |

## Verification
Each decoded bit is due exactly three clock edges after the bench drives the transition that opens the next cell. The bench records that cycle in a queue when it drives the edge, and on every clock it requires `bit_vld_o` to be high exactly on the queued cycles, with the queued bit. The loss-of-lock flag is sampled one cycle before and on the due edge: 4N+2 edges after the last transition for silence, three edges after an early transition, and one edge after a rate change. Lock acquisition is judged at the 16th strobe. Clock pulse widths are measured on every falling edge of `rclk_o` against N/2.

// File: rtl/bpm_cdr_pkg.sv
package bpm_cdr_pkg;

  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  // clocks per bit cell for a rate code; the fastest rate uses spb_fast
  function automatic int unsigned cell_len(input logic [1:0] r, input int unsigned spb_fast);
    return spb_fast << (2'd3 - r);
  endfunction

endpackage

// File: rtl/bpm_sync.sv
module bpm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], line_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign edge_o = sr_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/bpm_cell.sv
module bpm_cell
  import bpm_cdr_pkg::*;
#(
  parameter int unsigned SPB_FAST   = 8,
  parameter int unsigned IDLE_CELLS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       edge_i,
  input  logic [1:0] rate_i,
  input  logic       rate_chg_i,
  output logic       bit_o,
  output logic       bit_vld_o,
  output logic       rclk_o,
  output logic       emit_o,
  output logic       ferr_o,
  output logic       starve_o
);
  localparam int unsigned SPB_SLOW = SPB_FAST * 8;
  localparam int unsigned PW       = $clog2(SPB_SLOW * 2) + 1;
  localparam int unsigned IW       = $clog2(SPB_SLOW * IDLE_CELLS) + 1;
  localparam logic [PW-1:0] POS_MAX = '1;

  int unsigned   n_w;
  logic [PW-1:0] lo_c, hi_c, half_c;
  logic [IW-1:0] lim_c;
  logic [PW-1:0] pos_q, pos_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          framed_q, framed_d, mid_q, mid_d;
  logic          early, late, start;

  always_comb begin
    n_w    = cell_len(rate_i, SPB_FAST);
    lo_c   = PW'((n_w * 3) / 8);
    hi_c   = PW'((n_w * 5) / 8);
    half_c = PW'(n_w / 2);
    lim_c  = IW'(n_w * IDLE_CELLS);

    early    = pos_q < lo_c;
    late     = pos_q > hi_c;
    emit_o   = !rate_chg_i && edge_i && framed_q && late;
    ferr_o   = !rate_chg_i && edge_i && framed_q && early;
    start    = !rate_chg_i && edge_i && (!framed_q || late);
    starve_o = !rate_chg_i && !edge_i && (idle_q == lim_c - IW'(1));

    if (rate_chg_i)          pos_d = '0;
    else if (start)          pos_d = PW'(1);
    else if (pos_q != POS_MAX) pos_d = pos_q + PW'(1);
    else                     pos_d = pos_q;

    if (rate_chg_i || ferr_o || starve_o) framed_d = 1'b0;
    else if (start)                       framed_d = 1'b1;
    else                                  framed_d = framed_q;

    if (rate_chg_i || start || ferr_o)                mid_d = 1'b0;
    else if (edge_i && framed_q && !early && !late)   mid_d = 1'b1;
    else                                              mid_d = mid_q;

    if (rate_chg_i || edge_i) idle_d = '0;
    else if (idle_q != lim_c) idle_d = idle_q + IW'(1);
    else                      idle_d = idle_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      idle_q    <= '0;
      framed_q  <= 1'b0;
      mid_q     <= 1'b0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      rclk_o    <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      idle_q    <= idle_d;
      framed_q  <= framed_d;
      mid_q     <= mid_d;
      bit_vld_o <= emit_o;
      if (emit_o) bit_o <= mid_q;
      rclk_o    <= framed_d && (pos_d <= half_c);
    end
  end

  // R2: a cell is at least 5N/8 long, so strobes never touch
  p_vld_gap_r2: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |=> !bit_vld_o);

  // R5: each strobe coincides with the start of a recovered clock high phase
  p_vld_clk_r5: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |-> rclk_o);

endmodule

// File: rtl/bpm_lock.sv
module bpm_lock #(
  parameter int unsigned GOOD_CELLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic emit_i,
  input  logic ferr_i,
  input  logic starve_i,
  input  logic rate_chg_i,
  output logic lol_o
);
  localparam int unsigned GW = $clog2(GOOD_CELLS + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_CELLS - 1);

  logic [GW-1:0] good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= '0;
      lol_o  <= 1'b1;
    end else if (ferr_i || starve_i || rate_chg_i) begin
      good_q <= '0;
      lol_o  <= 1'b1;
    end else if (emit_i && lol_o) begin
      good_q <= good_q + GW'(1);
      if (good_q == GOOD_LAST) lol_o <= 1'b0;
    end
  end

  // R6: lock is only gained on a decoded cell
  p_unlock_on_bit_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(lol_o) |-> $past(emit_i));

  // R7: a silent line always drops lock
  p_starve_lol_r7: assert property (@(posedge clk) disable iff (rst)
    starve_i |=> lol_o);

  // R8: an early transition always drops lock
  p_ferr_lol_r8: assert property (@(posedge clk) disable iff (rst)
    ferr_i |=> lol_o);

endmodule

// File: rtl/bpm_cdr.sv
module bpm_cdr
  import bpm_cdr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPB_FAST    = 8,
  parameter int unsigned IDLE_CELLS  = 4,
  parameter int unsigned GOOD_CELLS  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  input  logic [1:0] rate_i,
  output logic       bit_o,
  output logic       bit_vld_o,
  output logic       rclk_o,
  output logic       lol_o
);
  logic [1:0] rate_q;
  logic       rate_chg;
  logic       edge_w, emit_w, ferr_w, starve_w;

  always_ff @(posedge clk) rate_q <= rate_i;

  assign rate_chg = !rst && (rate_i != rate_q);

  bpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_i),
    .edge_o (edge_w)
  );

  bpm_cell #(.SPB_FAST(SPB_FAST), .IDLE_CELLS(IDLE_CELLS)) u_cell (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (edge_w),
    .rate_i     (rate_q),
    .rate_chg_i (rate_chg),
    .bit_o      (bit_o),
    .bit_vld_o  (bit_vld_o),
    .rclk_o     (rclk_o),
    .emit_o     (emit_w),
    .ferr_o     (ferr_w),
    .starve_o   (starve_w)
  );

  bpm_lock #(.GOOD_CELLS(GOOD_CELLS)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .emit_i     (emit_w),
    .ferr_i     (ferr_w),
    .starve_i   (starve_w),
    .rate_chg_i (rate_chg),
    .lol_o      (lol_o)
  );

  // R9: switching rate forces loss of lock on the next edge
  p_rate_lol_r9: assert property (@(posedge clk) disable iff (rst)
    rate_chg |=> lol_o);

endmodule

// File: tb/sim_bpm_cdr.sv
module sim_bpm_cdr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b0;
  logic [1:0] rate = 2'd3;
  logic       bit_o, bit_vld, rclk, lol;

  bpm_cdr u0 (
    .clk(clk), .rst(rst), .line_i(line), .rate_i(rate),
    .bit_o(bit_o), .bit_vld_o(bit_vld), .rclk_o(rclk), .lol_o(lol)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int tq[$];
  bit bq[$];
  int nb = 0, half_exp = 4, run = 0, last_tr = 0;
  bit skip_clk = 1'b0, last_bit = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic bit exp_v = (tq.size() > 0) && (tq[0] == cyc);
      chk(bit_vld == exp_v, "R3 strobe cycle", int'(bit_vld), int'(exp_v));
      if (exp_v) begin
        automatic bit eb = bq.pop_front();
        void'(tq.pop_front());
        nb++;
        chk(bit_o == eb, "R1 R2 R4 decoded bit", int'(bit_o), int'(eb));
        chk(lol == (nb < 16), "R6 lock state at strobe", int'(lol), int'(nb < 16));
        chk(rclk == 1'b1, "R5 clock high at strobe", int'(rclk), 1);
      end
      if (rclk) run++;
      else if (run > 0) begin
        if (!skip_clk) chk(run == half_exp, "R5 clock high width", run, half_exp);
        run = 0;
      end
      if (cyc >= 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_cell(input bit b, input bit push, input bit prevb, input int n);
    automatic int jl = int'($urandom_range(2)) - 1;
    automatic int jm = int'($urandom_range(2)) - 1;
    automatic int len = n + jl;
    automatic int h = n / 2 + jm;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        line = ~line;
        last_tr = cyc;
        if (push) begin
          tq.push_back(cyc + 3);
          bq.push_back(prevb);
        end
      end else if (b && i == h) begin
        line = ~line;
        last_tr = cyc;
      end
    end
  endtask

  task automatic burst(input int ncell, input int n);
    automatic bit prev = 1'b0;
    nb = 0;
    for (int k = 0; k < ncell; k++) begin
      automatic bit b = 1'($urandom_range(1));
      send_cell(b, k > 0, prev, n);
      prev = b;
    end
    last_bit = prev;
  endtask

  task automatic starve_check(input int n);
    automatic int t0 = last_tr;
    wait_until(t0 + 4 * n + 2);
    chk(lol == 1'b0, "R7 lock held before silence limit", int'(lol), 0);
    wait_until(t0 + 4 * n + 3);
    chk(lol == 1'b1, "R7 lock lost after silence", int'(lol), 1);
    chk(rclk == 1'b0, "R7 R5 clock stopped when unframed", int'(rclk), 0);
    chk(tq.size() == 0, "R3 last cell not reported", tq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lol == 1'b1 && bit_vld == 1'b0 && rclk == 1'b0 && bit_o == 1'b0,
        "R10 outputs in reset", int'({bit_o, bit_vld, rclk, lol}), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(lol == 1'b1 && bit_vld == 1'b0 && rclk == 1'b0,
        "R10 outputs after reset", int'({bit_vld, rclk, lol}), 1);

    // every rate, fastest first
    for (int r = 3; r >= 0; r--) begin
      automatic int n = 8 << (3 - r);
      rate = 2'(r);
      half_exp = n / 2;
      repeat (10) @(negedge clk);
      burst(40, n);
      starve_check(n);
    end

    // R9: rate change while locked
    rate = 2'd3;
    half_exp = 4;
    repeat (10) @(negedge clk);
    burst(24, 8);
    wait_until(last_tr + 12);
    chk(lol == 1'b0, "R9 locked before rate change", int'(lol), 0);
    rate = 2'd1;
    half_exp = 16;
    @(negedge clk);
    chk(lol == 1'b1, "R9 lock lost on rate change", int'(lol), 1);
    repeat (40) @(negedge clk);
    chk(rclk == 1'b0, "R9 framing dropped after rate change", int'(rclk), 0);

    // R8: early transition in a framed cell
    burst(24, 32);
    begin
      automatic int g;
      @(negedge clk);
      line = ~line;
      tq.push_back(cyc + 3);
      bq.push_back(last_bit);
      skip_clk = 1'b1;
      repeat (3) @(negedge clk);
      line = ~line;
      g = cyc;
      last_tr = cyc;
      wait_until(g + 2);
      chk(lol == 1'b0, "R8 locked before early edge takes effect", int'(lol), 0);
      wait_until(g + 3);
      chk(lol == 1'b1, "R8 lock lost on early edge", int'(lol), 1);
    end
    repeat (4 * 32 + 20) @(negedge clk);
    skip_clk = 1'b0;
    chk(tq.size() == 0, "R8 no bit from broken cell", tq.size(), 0);
    burst(24, 32);
    starve_check(32);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule